// File: doc/BRIEF.md
# Real-Time Clock Host Register Port

This block is the processor-facing side of a real-time clock. It exposes a 128-byte register space through two byte addresses. A write to the even address selects a register. An access to the odd address then reads or writes the selected register. Four of the indices hold the clock's control and status state: a rate/status byte (A), a mode byte (B), an event flag byte (C) and a validity byte (D). Every other index is a plain storage byte that keeps its contents across a block reset.

Separate logic does the time counting and the alarm comparison. That logic sends single-cycle pulses to this block: the start of an update cycle, the end of an update cycle, an alarm match and a periodic tick. The port records these pulses as flags, combines the flags with the enables held in the mode byte, and drives one level interrupt request. A processor services the interrupt by reading the flag byte. That read returns the flags, clears them and drops the request.

Top module: `rtc_host_port`

## Requirements
- R1: A write to the even address (`bus_port`=0) stores `bus_wdata[6:0]` as the register index and ignores bit 7. A read of the even address returns 0xFF. An access to the odd address (`bus_port`=1) reaches the register at the stored index.
- R2: After reset, index 0x0A (A) reads 0x26, index 0x0B (B) reads 0x02, index 0x0C (C) reads 0x00, index 0x0D (D) reads 0x80, and `irq` is low.
- R3: Reading C returns its current value. After that read, C holds 0x00 and `irq` is low, except for any event that arrives in the same cycle as the read, which is recorded after the clear.
- R4: Writes to C and D have no effect on their contents.
- R5: Bit 7 of A is an update-in-progress flag that the host cannot write. A host write to A changes only bits 6:0. An `upd_start` pulse sets the flag while B bit 7 is 0. An `ev_update` pulse clears it.
- R6: A write to B with bit 7 (halt) set stores bit 4 (update enable) as 0 and clears the update-in-progress flag. While B bit 7 is 1, `upd_start` has no effect.
- R7: When B is written and any of C bits 6:4 is set together with the matching bit of the newly stored B (bit 6 periodic, bit 5 alarm, bit 4 update), C bit 7 is set and `irq` rises on the next cycle. Otherwise C bit 7 and `irq` are cleared.
- R8: An `ev_update` pulse sets C bit 4, and an `ev_alarm` pulse sets C bit 5. C bit 7 and `irq` are raised only when the flag was not already set and its enable (B bit 4 or B bit 5) is 1.
- R9: An `ev_periodic` pulse sets C bit 6. It raises C bit 7 and `irq` whenever B bit 6 is 1.
- R10: Every index other than 0x0A to 0x0D reads back the last byte written to it.
- R11: `irq` follows C bit 7. It is registered, so it changes on the clock edge after the access or event that sets or clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_port | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is strobed |
| upd_start | input | 1 | Pulse: an update cycle is starting |
| ev_update | input | 1 | Pulse: an update cycle has ended |
| ev_alarm | input | 1 | Pulse: the alarm time matched |
| ev_periodic | input | 1 | Pulse: a periodic tick occurred |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench first raises each event with its enable off and then turns the enable on by writing B. This separates a flag that is only recorded from one that raises the interrupt at once. It also clears an enable while its flag is pending, which must drop the request but keep the flag. Separate tests cover periodic ticks that repeat without an intervening read, a flag read that lands in the same cycle as a new update event, and the halt bit's effect on both the update enable and the update-in-progress flag. These tests tell a correct clear-on-read and newly-set rule apart from simpler flag handling. Storage indices at both ends of the space, and an index written with bit 7 set, confirm that the address decode does not alias.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

  localparam int unsigned A_UIP   = 7;
  localparam int unsigned B_HALT  = 7;
  localparam int unsigned B_PIE   = 6;
  localparam int unsigned B_AIE   = 5;
  localparam int unsigned B_UIE   = 4;
  localparam int unsigned C_IRQF  = 7;

  localparam logic [7:0] A_RESET = 8'h26;
  localparam logic [7:0] B_RESET = 8'h02;
  localparam logic [7:0] D_VALUE = 8'h80;

  // Flag vector order used inside the flag unit: {periodic, alarm, update}.
  typedef logic [2:0] evt_vec_t;

  // Stored value of the mode byte for a given host write.
  function automatic logic [7:0] mode_write_value(input logic [7:0] d);
    logic [7:0] v;
    v = d;
    if (d[B_HALT]) v[B_UIE] = 1'b0;
    return v;
  endfunction

  // True when any flag is pending together with its enable.
  function automatic logic pending_hit(input evt_vec_t en, input evt_vec_t fl);
    return |(en & fl);
  endfunction

endpackage

// File: rtl/rtc_index_latch.sv
module rtc_index_latch #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] idx_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_wr) idx_q <= idx_in;
  end

  assert_index_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(idx_in));

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_wr,
  input  logic       b_wr,
  input  logic [7:0] wdata,
  input  logic       upd_start,
  input  logic       upd_ev,
  output logic [7:0] a_q,
  output logic [7:0] b_q,
  output logic [7:0] b_new
);

  logic       uip_q;
  logic [6:0] a_low_q;
  logic       uip_clr;
  logic       uip_set;

  assign b_new   = mode_write_value(wdata);
  assign uip_clr = (b_wr && wdata[B_HALT]) || upd_ev;
  assign uip_set = upd_start && !b_q[B_HALT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uip_q   <= A_RESET[A_UIP];
      a_low_q <= A_RESET[6:0];
      b_q     <= B_RESET;
    end else begin
      if (a_wr) a_low_q <= wdata[6:0];
      if (b_wr) b_q <= b_new;
      if (uip_clr) uip_q <= 1'b0;
      else if (uip_set) uip_q <= 1'b1;
    end
  end

  assign a_q = {uip_q, a_low_q};

  assert_uip_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && !upd_ev && !upd_start) |=> $stable(a_q[A_UIP]));

  assert_uip_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ev |=> !a_q[A_UIP]);

  assert_halt_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && wdata[B_HALT]) |=> (!b_q[B_UIE] && !a_q[A_UIP]));

  assert_halt_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q[B_HALT] && !b_wr && !a_q[A_UIP]) |=> !a_q[A_UIP]);

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  evt_vec_t   en_q,
  input  logic       b_wr,
  input  evt_vec_t   en_new,
  input  logic       c_rd,
  input  logic       c_wr,
  input  logic       ev_upd,
  input  logic       ev_alm,
  input  logic       ev_per,
  output logic [7:0] c_q,
  output logic       irq
);

  evt_vec_t flag_q;
  logic     irqf_q;
  evt_vec_t ev_vec;
  evt_vec_t base;
  evt_vec_t fresh;
  logic     trig;
  logic     irqf_next;
  logic     ev_any;

  assign ev_vec = {ev_per, ev_alm, ev_upd};
  assign ev_any = |ev_vec;
  assign base   = c_rd ? '0 : flag_q;
  assign fresh  = ev_vec & ~base;
  // Alarm and update interrupt only on a fresh flag; periodic on every tick.
  assign trig   = pending_hit(en_q[1:0], fresh[1:0]) || (ev_per && en_q[2]);

  always_comb begin
    if (b_wr)      irqf_next = pending_hit(en_new, base) || trig;
    else if (c_rd) irqf_next = trig;
    else           irqf_next = irqf_q || trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irqf_q <= 1'b0;
    end else begin
      flag_q <= base | ev_vec;
      irqf_q <= irqf_next;
    end
  end

  assign c_q = {irqf_q, flag_q, 4'b0000};
  assign irq = irqf_q;

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && !ev_any) |=> (c_q == 8'h00 && !irq));

  assert_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && !ev_any) |=> $stable(c_q));

  assert_enable_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && pending_hit(en_new, flag_q)) |=> irq);

  assert_enable_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && !pending_hit(en_new, flag_q) && !ev_any) |=> !irq);

  assert_update_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_upd && !c_q[4] && en_q[0]) |=> (irq && c_q[4]));

  assert_periodic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_per && en_q[2]) |=> (irq && c_q[6]));

endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Battery-backed bytes: deliberately not touched by the block reset.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

  assert_store_keeps_R10: assert property (@(posedge clk)
    we |=> mem[$past(idx)] == $past(wdata));

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_port_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter logic [6:0]  IDX_A = 7'h0A,
  parameter logic [6:0]  IDX_B = 7'h0B,
  parameter logic [6:0]  IDX_C = 7'h0C,
  parameter logic [6:0]  IDX_D = 7'h0D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_port,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       upd_start,
  input  logic       ev_update,
  input  logic       ev_alarm,
  input  logic       ev_periodic,
  output logic       irq
);

  localparam logic [7:0] IDLE_READ = 8'hFF;

  logic [IDX_W-1:0] idx_q;
  logic idx_wr, data_wr, data_rd;
  logic hit_a, hit_b, hit_c, hit_d, hit_ctrl;
  logic [7:0] a_q, b_q, b_new, c_q, store_rd;

  assign idx_wr  = bus_sel &&  bus_wr && !bus_port;
  assign data_wr = bus_sel &&  bus_wr &&  bus_port;
  assign data_rd = bus_sel && !bus_wr &&  bus_port;

  assign hit_a    = (idx_q == IDX_A[IDX_W-1:0]);
  assign hit_b    = (idx_q == IDX_B[IDX_W-1:0]);
  assign hit_c    = (idx_q == IDX_C[IDX_W-1:0]);
  assign hit_d    = (idx_q == IDX_D[IDX_W-1:0]);
  assign hit_ctrl = hit_a || hit_b || hit_c || hit_d;

  rtc_index_latch #(.IDX_W(IDX_W)) u_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .idx_in (bus_wdata[IDX_W-1:0]),
    .idx_q  (idx_q)
  );

  rtc_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_wr      (data_wr && hit_a),
    .b_wr      (data_wr && hit_b),
    .wdata     (bus_wdata),
    .upd_start (upd_start),
    .upd_ev    (ev_update),
    .a_q       (a_q),
    .b_q       (b_q),
    .b_new     (b_new)
  );

  rtc_flag_unit u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_q   (b_q[B_PIE:B_UIE]),
    .b_wr   (data_wr && hit_b),
    .en_new (b_new[B_PIE:B_UIE]),
    .c_rd   (data_rd && hit_c),
    .c_wr   (data_wr && hit_c),
    .ev_upd (ev_update),
    .ev_alm (ev_alarm),
    .ev_per (ev_periodic),
    .c_q    (c_q),
    .irq    (irq)
  );

  rtc_byte_store #(.IDX_W(IDX_W), .DATA_W(8)) u_store (
    .clk   (clk),
    .we    (data_wr && !hit_ctrl),
    .idx   (idx_q),
    .wdata (bus_wdata),
    .rdata (store_rd)
  );

  always_comb begin
    if (!bus_port)  bus_rdata = IDLE_READ;
    else if (hit_a) bus_rdata = a_q;
    else if (hit_b) bus_rdata = b_q;
    else if (hit_c) bus_rdata = c_q;
    else if (hit_d) bus_rdata = D_VALUE;
    else            bus_rdata = store_rd;
  end

  assert_irq_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && hit_c && bus_rdata[C_IRQF] && !ev_update && !ev_alarm && !ev_periodic)
      |=> $fell(irq));

endmodule

// File: tb/rtc_host_port_bench.sv
module rtc_host_port_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_port = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic upd_start = 1'b0, ev_update = 1'b0, ev_alarm = 1'b0, ev_periodic = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_host_port u_rtc_host_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_start(upd_start), .ev_update(ev_update), .ev_alarm(ev_alarm),
    .ev_periodic(ev_periodic), .irq(irq)
  );

  // Monitor: compares every strobed read against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_bus();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_port = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic set_index(input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_port = 1'b0; bus_wdata = d;
    step(); clear_bus();
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    set_index(idx);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_port = 1'b1; bus_wdata = d;
    step(); clear_bus();
  endtask

  task automatic rd_data(input logic [7:0] e, input string t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_port = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    step(); clear_bus();
  endtask

  task automatic rd_reg(input logic [7:0] idx, input logic [7:0] e, input string t);
    set_index(idx);
    rd_data(e, t);
  endtask

  task automatic rd_even(input logic [7:0] e, input string t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_port = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    step(); clear_bus();
  endtask

  task automatic pulse(input int which);
    case (which)
      0: upd_start = 1'b1;
      1: ev_update = 1'b1;
      2: ev_alarm = 1'b1;
      default: ev_periodic = 1'b1;
    endcase
    step();
    upd_start = 1'b0; ev_update = 1'b0; ev_alarm = 1'b0; ev_periodic = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R2 reset state
    check_irq(1'b0, "R2 irq after reset");
    rd_reg(8'h0A, 8'h26, "R2 A reset");
    rd_reg(8'h0B, 8'h02, "R2 B reset");
    rd_reg(8'h0C, 8'h00, "R2 C reset");
    rd_reg(8'h0D, 8'h80, "R2 D reset");
    rd_even(8'hFF, "R1 even read");

    // R10 storage bytes, R1 index bit 7 ignored
    wr_reg(8'h20, 8'h5A);
    wr_reg(8'h7F, 8'hC3);
    wr_reg(8'h0E, 8'h11);
    rd_reg(8'h7F, 8'hC3, "R10 top index");
    rd_reg(8'h0E, 8'h11, "R10 next to D");
    rd_reg(8'hA0, 8'h5A, "R1 index bit7 dropped");

    // R4 writes to C and D ignored
    wr_reg(8'h0C, 8'hFF);
    rd_reg(8'h0C, 8'h00, "R4 C write ignored");
    wr_reg(8'h0D, 8'h00);
    rd_reg(8'h0D, 8'h80, "R4 D write ignored");
    check_irq(1'b0, "R4 irq after C write");

    // R5 update-in-progress flag
    pulse(0);
    rd_reg(8'h0A, 8'hA6, "R5 uip set by start");
    wr_reg(8'h0A, 8'h05);
    rd_reg(8'h0A, 8'h85, "R5 uip kept on write");
    pulse(1);
    check_irq(1'b0, "R8 update with enable off");
    rd_reg(8'h0A, 8'h05, "R5 uip cleared by update end");
    rd_reg(8'h0C, 8'h10, "R8 update flag recorded");
    rd_data(8'h00, "R3 C cleared by read");

    // R8 enabled update interrupt, R3 clear on read
    wr_reg(8'h0B, 8'h12);
    check_irq(1'b0, "R7 nothing pending");
    pulse(1);
    check_irq(1'b1, "R8 update raises irq");
    rd_reg(8'h0C, 8'h90, "R8 C with irq flag");
    check_irq(1'b0, "R3 irq dropped by read");

    // R7 enable over a pending flag, and disable
    wr_reg(8'h0B, 8'h02);
    pulse(2);
    check_irq(1'b0, "R8 alarm with enable off");
    wr_reg(8'h0B, 8'h22);
    check_irq(1'b1, "R7 enable over pending alarm");
    wr_reg(8'h0B, 8'h02);
    check_irq(1'b0, "R7 disable drops irq");
    rd_reg(8'h0C, 8'h20, "R7 alarm flag kept, irq flag cleared");

    // R9 periodic
    pulse(3);
    check_irq(1'b0, "R9 tick with enable off");
    wr_reg(8'h0B, 8'h42);
    check_irq(1'b1, "R7 enable over pending tick");
    rd_reg(8'h0C, 8'hC0, "R9 periodic flags");
    check_irq(1'b0, "R11 irq follows flag");
    pulse(3);
    check_irq(1'b1, "R9 tick raises irq");
    pulse(3);
    check_irq(1'b1, "R9 repeated tick");
    rd_data(8'hC0, "R9 C after two ticks");
    rd_data(8'h00, "R3 C empty after read");

    // R3 read of C in the same cycle as an update event
    wr_reg(8'h0B, 8'h12);
    set_index(8'h0C);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_port = 1'b1; ev_update = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R3 read returns old C");
    step(); clear_bus(); ev_update = 1'b0;
    check_irq(1'b1, "R3 event kept after clear");
    rd_data(8'h90, "R3 event flag survives read");

    // R6 halt bit
    pulse(0);
    rd_reg(8'h0A, 8'h85, "R5 uip set again");
    wr_reg(8'h0B, 8'h92);
    check_irq(1'b0, "R6 no pending after halt write");
    rd_reg(8'h0B, 8'h82, "R6 update enable forced off");
    rd_reg(8'h0A, 8'h05, "R6 uip cleared by halt");
    pulse(0);
    rd_reg(8'h0A, 8'h05, "R6 start ignored while halted");
    pulse(1);
    check_irq(1'b0, "R6 update does not interrupt");
    rd_reg(8'h0C, 8'h10, "R8 flag set while halted");

    step();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule